// File: doc/BRIEF.md
# Four-Entry Transfer Byte Buffer

This block holds up to four bytes between a register interface and the bus transfer sequencer of a two-wire serial controller. Software places bytes into it with a push strobe (a write to the data location) and takes them out with a pop strobe (a read of the same location). Bytes leave in the order they arrived: each pop returns the oldest byte and moves the rest toward the head. The sequencer sees every stored byte and the fill level, and it can replace the whole contents in one cycle with the bytes it has received from the bus.

Two flags report the fill state, one for "at least one byte held" and one for "all four held". Both come from a single fill counter that runs from zero to the depth. A flush strobe, which the register decoder raises when software writes the mode control register with its flush bit set, empties the buffer and zeroes every entry. A synchronous soft reset and the asynchronous reset do the same. Reading an empty buffer gives the fill byte 0xFF and changes nothing, and a push into a full buffer is dropped.

Top module: `xfer_byte_buffer`

## Requirements
- R1: Pushed bytes are stored at the next free index (index 0 first), and later pops return them in the order they were pushed.
- R2: A push while four bytes are held, with no pop in the same cycle, is dropped: level and all entries stay as they were.
- R3: `has_data` is 1 exactly when the level is at least 1 and `full` is 1 exactly when the level is 4, so the first push sets `has_data`, the fourth push sets `full`, a pop from level 4 clears `full` and a pop from level 1 clears `has_data`.
- R4: A pop while empty returns 0xFF on `sw_rdata` in the same cycle and changes neither level nor entries.
- R5: A pop while non-empty returns entry 0 on `sw_rdata` in the cycle of the strobe; after the clock edge every entry has moved down one index, the top entry is zero and the level is one lower.
- R6: A `flush` strobe makes level 0, all entries zero and both flags 0 after the next clock edge.
- R7: The asynchronous reset `rst_n` low and the synchronous `soft_rst` strobe each leave level 0, all entries zero and both flags 0.
- R8: A `seq_load` strobe with count n sets the level to the smaller of n and 4; entry i takes `seq_load_data[8i+7:8i]` for i below that level and zero otherwise.
- R9: A `seq_load` in the same cycle as a push or pop wins: the software strobe is ignored. `flush` and `soft_rst` win over `seq_load`.
- R10: A push and a pop in the same cycle are taken pop first: the pop returns entry 0 and the pushed byte goes to the index freed after the shift, so a full buffer stays full with the new byte at index 3.
- R11: `seq_entries` shows entry i at bits 8i+7:8i and `level` shows the fill count from 0 to 4, both updated one clock edge after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous reset strobe from the controller's software reset |
| flush | input | 1 | Empty and zero the buffer (mode-control flush bit written) |
| sw_push | input | 1 | Software write of the data location |
| sw_wdata | input | 8 | Byte written by software |
| sw_pop | input | 1 | Software read of the data location |
| sw_rdata | output | 8 | Entry 0, or 0xFF when empty |
| seq_load | input | 1 | Sequencer bulk load strobe |
| seq_load_cnt | input | 3 | Number of bytes in the bulk load |
| seq_load_data | input | 32 | Bulk load bytes, byte i at bits 8i+7:8i |
| seq_entries | output | 32 | All entries, entry i at bits 8i+7:8i |
| level | output | 3 | Number of bytes held |
| has_data | output | 1 | At least one byte held |
| full | output | 1 | Four bytes held |

## Verification
The in-design properties watch on every cycle that the level never exceeds the depth, that a dropped push or an empty pop leaves the level alone, that a plain pop lowers it by one, that a bulk load or clear overrides software strobes, and that a clear leaves every entry zero. Byte ordering through pushes and pops, the 0xFF read value, the clamping of an oversized bulk load, the combined push-and-pop case and the behaviour of both resets need concrete data, and only the bench's scenarios against its own queue model show them.

// File: rtl/xfer_byte_buffer_pkg.sv
package xfer_byte_buffer_pkg;

   // Width of a counter that must hold the values 0..depth inclusive.
   function automatic int level_width(input int depth);
      return $clog2(depth + 1);
   endfunction

   // Source selected for each entry on a clock edge.
   typedef enum logic [1:0] {
      SRC_HOLD  = 2'd0,
      SRC_CLEAR = 2'd1,
      SRC_LOAD  = 2'd2,
      SRC_SHIFT = 2'd3
   } entry_src_e;

endpackage

// File: rtl/xfer_byte_buffer_level.sv
module xfer_byte_buffer_level #(
   parameter int DEPTH = 4,
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [LVL_W-1:0] load_cnt,
   input  logic             push,
   input  logic             pop,
   output logic [LVL_W-1:0] level,
   output logic [LVL_W-1:0] push_idx,
   output logic             pop_ok,
   output logic             push_ok,
   output logic             has_data,
   output logic             full
);

   localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);
   localparam logic [LVL_W-1:0] ZERO_L  = '0;

   logic [LVL_W-1:0] cnt_q;
   logic [LVL_W-1:0] cnt_d;
   logic [LVL_W-1:0] post_pop;
   logic [LVL_W-1:0] load_lvl;
   logic             sw_allowed;

   assign sw_allowed = ~clear & ~load;
   assign pop_ok     = sw_allowed & pop & (cnt_q != ZERO_L);
   assign post_pop   = cnt_q - LVL_W'(pop_ok);
   assign push_ok    = sw_allowed & push & (post_pop < DEPTH_L);
   assign push_idx   = post_pop;
   assign load_lvl   = (load_cnt > DEPTH_L) ? DEPTH_L : load_cnt;

   always_comb begin
      if (clear) begin
         cnt_d = ZERO_L;
      end else if (load) begin
         cnt_d = load_lvl;
      end else begin
         cnt_d = post_pop + LVL_W'(push_ok);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ZERO_L;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign level    = cnt_q;
   assign has_data = (cnt_q != ZERO_L);
   assign full     = (cnt_q == DEPTH_L);

   // R3: level never passes the depth, so full is the ceiling
   p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= DEPTH_L);

   // R2: a lone push into a full buffer leaves the level alone
   p_drop_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !load && !clear) |=> (cnt_q == DEPTH_L));

   // R4: a pop from empty changes nothing
   p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!has_data && pop && !push && !load && !clear) |=> (cnt_q == ZERO_L));

   // R5: a plain pop lowers the level by one
   p_pop_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (has_data && pop && !push && !load && !clear) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R9: a bulk load or clear masks the software strobes
   p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (load || clear) |-> (!pop_ok && !push_ok));

   // R6: clear empties the buffer on the next edge
   p_clear_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == ZERO_L));

endmodule

// File: rtl/xfer_byte_buffer_store.sv
module xfer_byte_buffer_store
   import xfer_byte_buffer_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int WIDTH = 8,
   parameter int LVL_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   load,
   input  logic [LVL_W-1:0]       load_cnt,
   input  logic [DEPTH*WIDTH-1:0] load_data,
   input  logic                   pop_ok,
   input  logic                   push_ok,
   input  logic [LVL_W-1:0]       push_idx,
   input  logic [WIDTH-1:0]       wdata,
   output logic [DEPTH*WIDTH-1:0] entries
);

   localparam int               TOTAL_W = DEPTH * WIDTH;
   localparam logic [WIDTH-1:0] ZERO_B  = '0;

   logic [WIDTH-1:0] ent_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      localparam logic [LVL_W-1:0] IDX = LVL_W'(i);

      entry_src_e       src;
      logic [WIDTH-1:0] upper;
      logic [WIDTH-1:0] shifted;
      logic [WIDTH-1:0] ent_d;

      // Byte that slides in from above on a pop; the top entry takes zero.
      if (i == DEPTH - 1) begin : g_top
         assign upper = ZERO_B;
      end else begin : g_mid
         assign upper = ent_q[i+1];
      end

      always_comb begin
         if (clear) begin
            src = SRC_CLEAR;
         end else if (load) begin
            src = SRC_LOAD;
         end else if (pop_ok || push_ok) begin
            src = SRC_SHIFT;
         end else begin
            src = SRC_HOLD;
         end
      end

      always_comb begin
         shifted = pop_ok ? upper : ent_q[i];
         if (push_ok && (push_idx == IDX)) begin
            shifted = wdata;
         end
      end

      always_comb begin
         unique case (src)
            SRC_CLEAR: ent_d = ZERO_B;
            SRC_LOAD:  ent_d = (IDX < load_cnt) ? load_data[i*WIDTH +: WIDTH] : ZERO_B;
            SRC_SHIFT: ent_d = shifted;
            default:   ent_d = ent_q[i];
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q[i] <= ZERO_B;
         end else begin
            ent_q[i] <= ent_d;
         end
      end

      assign entries[i*WIDTH +: WIDTH] = ent_q[i];
   end

   // R6: every entry is zero after a clear
   p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (entries == TOTAL_W'(0)));

   // R5: a lone pop moves entry 1 into entry 0
   p_shift_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok && !push_ok && !clear && !load)
         |=> (entries[WIDTH-1:0] == $past(entries[2*WIDTH-1:WIDTH])));

endmodule

// File: rtl/xfer_byte_buffer.sv
module xfer_byte_buffer
   import xfer_byte_buffer_pkg::*;
#(
   parameter int               DEPTH      = 4,
   parameter int               WIDTH      = 8,
   parameter logic [WIDTH-1:0] EMPTY_FILL = 8'hFF,
   localparam int              LVL_W      = level_width(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   soft_rst,
   input  logic                   flush,
   input  logic                   sw_push,
   input  logic [WIDTH-1:0]       sw_wdata,
   input  logic                   sw_pop,
   output logic [WIDTH-1:0]       sw_rdata,
   input  logic                   seq_load,
   input  logic [LVL_W-1:0]       seq_load_cnt,
   input  logic [DEPTH*WIDTH-1:0] seq_load_data,
   output logic [DEPTH*WIDTH-1:0] seq_entries,
   output logic [LVL_W-1:0]       level,
   output logic                   has_data,
   output logic                   full
);

   // Elaboration-time parameter checks.
   if (DEPTH < 2) begin : g_bad_depth
      $error("xfer_byte_buffer: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("xfer_byte_buffer: WIDTH must be at least 1");
   end

   logic             clear;
   logic             pop_ok;
   logic             push_ok;
   logic [LVL_W-1:0] push_idx;

   assign clear = flush | soft_rst;

   xfer_byte_buffer_level #(
      .DEPTH (DEPTH),
      .LVL_W (LVL_W)
   ) u_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .load     (seq_load),
      .load_cnt (seq_load_cnt),
      .push     (sw_push),
      .pop      (sw_pop),
      .level    (level),
      .push_idx (push_idx),
      .pop_ok   (pop_ok),
      .push_ok  (push_ok),
      .has_data (has_data),
      .full     (full)
   );

   xfer_byte_buffer_store #(
      .DEPTH (DEPTH),
      .WIDTH (WIDTH),
      .LVL_W (LVL_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .load      (seq_load),
      .load_cnt  (seq_load_cnt),
      .load_data (seq_load_data),
      .pop_ok    (pop_ok),
      .push_ok   (push_ok),
      .push_idx  (push_idx),
      .wdata     (sw_wdata),
      .entries   (seq_entries)
   );

   assign sw_rdata = has_data ? seq_entries[WIDTH-1:0] : EMPTY_FILL;

   // R4: an empty pop leaves the stored bytes untouched
   p_empty_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!has_data && sw_pop && !sw_push && !seq_load && !clear) |=> $stable(seq_entries));

   // R10: push with pop on a full buffer keeps it full
   p_swap_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (full && sw_pop && sw_push && !seq_load && !clear) |=> full);

endmodule

// File: tb/xfer_byte_buffer_test.sv
module xfer_byte_buffer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        flush = 1'b0;
   logic        sw_push = 1'b0;
   logic [7:0]  sw_wdata = '0;
   logic        sw_pop = 1'b0;
   logic [7:0]  sw_rdata;
   logic        seq_load = 1'b0;
   logic [2:0]  seq_load_cnt = '0;
   logic [31:0] seq_load_data = '0;
   logic [31:0] seq_entries;
   logic [2:0]  level;
   logic        has_data;
   logic        full;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [7:0] exp_q [$];

   always #5 clk = ~clk;

   xfer_byte_buffer uut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .flush(flush),
      .sw_push(sw_push), .sw_wdata(sw_wdata), .sw_pop(sw_pop), .sw_rdata(sw_rdata),
      .seq_load(seq_load), .seq_load_cnt(seq_load_cnt), .seq_load_data(seq_load_data),
      .seq_entries(seq_entries), .level(level), .has_data(has_data), .full(full)
   );

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // Monitor side: compare every visible output against the queue model.
   task automatic check_state(input string tag);
      int sz = exp_q.size();
      cmp(tag, "level", int'(level), sz);
      cmp(tag, "has_data", int'(has_data), int'(sz > 0));
      cmp(tag, "full", int'(full), int'(sz == 4));
      for (int i = 0; i < 4; i++) begin
         cmp(tag, $sformatf("entry%0d", i), int'(seq_entries[8*i +: 8]),
             (i < sz) ? int'(exp_q[i]) : 0);
      end
   endtask

   // Driver side: one clock of stimulus; the model queue is updated alongside.
   task automatic step(input string tag, input bit push, input logic [7:0] wd, input bit pop,
                       input bit fl, input bit srst, input bit ld,
                       input logic [2:0] lcnt, input logic [31:0] ldata);
      int ncnt;
      @(negedge clk);
      sw_push = push; sw_wdata = wd; sw_pop = pop; flush = fl; soft_rst = srst;
      seq_load = ld; seq_load_cnt = lcnt; seq_load_data = ldata;
      #1;
      if (pop) begin
         cmp(tag, "rdata", int'(sw_rdata), (exp_q.size() == 0) ? 8'hFF : int'(exp_q[0]));
      end
      if (fl || srst) begin
         exp_q.delete();
      end else if (ld) begin
         exp_q.delete();
         ncnt = (lcnt > 3'd4) ? 4 : int'(lcnt);
         for (int i = 0; i < ncnt; i++) exp_q.push_back(ldata[8*i +: 8]);
      end else begin
         if (pop && exp_q.size() > 0) void'(exp_q.pop_front());
         if (push && exp_q.size() < 4) exp_q.push_back(wd);
      end
      @(posedge clk);
      #1;
      sw_push = 1'b0; sw_pop = 1'b0; flush = 1'b0; soft_rst = 1'b0; seq_load = 1'b0;
      check_state(tag);
   endtask

   task automatic push_b(input string tag, input logic [7:0] b);
      step(tag, 1'b1, b, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0);
   endtask

   task automatic pop_b(input string tag);
      step(tag, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check_state("R7 reset");
      cmp("R4", "rdata idle empty", int'(sw_rdata), 8'hFF);
      rst_n = 1'b1;

      pop_b("R4 empty pop");
      push_b("R1 R3 first push", 8'hA1);
      push_b("R1", 8'hA2);
      push_b("R1", 8'hA3);
      push_b("R3 fourth push", 8'hA4);
      push_b("R2 full drop", 8'hEE);
      pop_b("R5 R3 pop from full");
      step("R10 push+pop", 1'b1, 8'hB5, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0);
      push_b("R3 refill", 8'hB6);
      step("R10 full swap", 1'b1, 8'hB7, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0);
      for (int k = 0; k < 4; k++) pop_b("R1 R5 drain");
      pop_b("R4 drained pop");
      step("R10 empty push+pop", 1'b1, 8'hC1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0);
      push_b("R1", 8'hC2);
      step("R6 flush", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'd0);
      step("R8 load 3", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 32'h44332211);
      pop_b("R8 R11 first loaded");
      step("R9 load beats push", 1'b1, 8'hDD, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 32'h99887766);
      step("R8 load clamp", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7, 32'hF4F3F2F1);
      step("R8 load zero", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 32'hFFFFFFFF);
      step("R9 flush beats load", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 3'd4, 32'h12345678);
      push_b("R1", 8'h5A);
      push_b("R1", 8'h5B);
      step("R7 soft reset", 1'b1, 8'h77, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 32'd0);
      push_b("R11", 8'h61);
      push_b("R11", 8'h62);
      push_b("R11", 8'h63);
      @(negedge clk);
      rst_n = 1'b0;
      exp_q.delete();
      #1;
      check_state("R7 async reset");
      @(negedge clk);
      rst_n = 1'b1;
      push_b("R1 after reset", 8'h70);
      pop_b("R5 after reset");

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule